// File: doc/BRIEF.md
# SPI Master Controller with Polled Status Flags

This block is a single-channel SPI master that a small processor drives through four byte-wide registers. Software sets an enable bit and a master bit, picks a serial clock rate from a prescaler field and a power-of-two field, and then moves bytes through one shared data address. A write to that address queues a byte for sending. A read returns the byte that was last captured. Two status flags pace the software loop: one says the transmit holding register is free, and the other says a received byte is waiting.

The transmit side has a holding register in front of the shifter. A second byte can therefore be queued while the first one is still on the wire, and the free flag comes back as soon as the held byte moves into the shifter. The receive side has a single buffer. Its full flag is cleared by a status read that shows the flag set, followed by a data read. Frames are 8 bits, sent most significant bit first, in mode 0. Chip select is left to a general-purpose output outside this block.

Register map (byte-wide bus, 2-bit address):

| Address | Register | Fields |
|---------|----------|--------|
| 0 | control | bit0 enable, bit1 master |
| 1 | clock rate | bits [2:0] rate R, bits [5:3] prescale P |
| 2 | status | bit0 receive-full, bit1 transmit-free |
| 3 | data | write queues a byte, read returns the received byte |

Top module: `spi_master_ctrl`

## Requirements
- R1: The SCLK period is (P+1)·2^(R+1) bus clocks, and each high phase lasts (P+1)·2^R bus clocks. P is the prescale field (clock-rate register bits [5:3]) and R is the rate field (bits [2:0]).
- R2: With P=0 and R=0, SCLK runs at half the bus clock: a period of 2 cycles and a high phase of 1 cycle.
- R3: No frame starts unless control bit0 (enable) and bit1 (master) are both set. A byte queued while either bit is clear stays held, SCLK stays low, and status bit1 reads 0.
- R4: A frame is 8 bits, most significant bit first, in mode 0. SCLK idles low, MOSI changes only while SCLK is low, and MISO is captured on each rising SCLK edge.
- R5: Status bit1 (transmit-free) is 1 whenever the holding register is empty. An accepted data write clears it. It returns to 1 when the held byte moves into the shifter, which happens before that frame ends.
- R6: A data write is accepted only if a status read that showed bit1 set came after the last accepted data write. Any other data write is ignored and sends nothing.
- R7: When a frame completes and status bit0 (receive-full) is clear, the received byte goes into the receive buffer, bit0 sets, and a read of address 3 returns the byte.
- R8: A data read clears status bit0 only if a status read showing bit0 set came before it. A data read without that status read leaves bit0 set.
- R9: If a frame completes while status bit0 is set, its byte is dropped, and the receive buffer keeps the earlier byte.
- R10: Two bytes queued back to back go out as consecutive frames. With MOSI looped to MISO, they come back in the order they were written.
- R11: After reset the control and clock-rate registers read 0, status reads 0x02, and SCLK and MOSI are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier (reads of status and data have side effects) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench loops MOSI back to MISO and sweeps a grid of prescale and rate settings. For each setting it measures the SCLK period and high time and records the bit order on the wire; a divider with an off-by-one error, or a shifter that sends LSB first, shows up at once. Several sequences target the flag handshakes:
- a second byte queued during a frame, which a single-buffered design would never take;
- a write made without a preceding status read, which a design that ignores the arming rule would send;
- a data read without a preceding status read, which a careless design would treat as a clear;
- a frame that completes over a full buffer, where a design that overwrites would lose the older byte.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_BAUD = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_DATA = 2'd3
    } spi_addr_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_MST_BIT = 1;
    localparam int STAT_RXF_BIT = 0;
    localparam int STAT_TXE_BIT = 1;

endpackage

// File: rtl/spi_mst_clkdiv.sv
module spi_mst_clkdiv #(
    parameter int PRE_W  = 3,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [PRE_W-1:0]  pre_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o
);
    // Half-period = (P+1) << R; counter must hold values up to that.
    localparam int CNT_W = PRE_W + (1 << RATE_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [CNT_W-1:0] half;

    assign half   = (CNT_W'(pre_i) + CNT_W'(1)) << rate_i;
    // ">=" keeps the counter from running away if the rate shrinks mid-frame
    assign tick_o = run_i && (st_q.cnt >= half - CNT_W'(1));

    always_comb begin
        st_d = st_q;
        if (!run_i)      st_d.cnt = '0;
        else if (tick_o) st_d.cnt = '0;
        else             st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/spi_mst_shifter.sv
module spi_mst_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tick_i,
    input  logic              miso_i,
    output logic              busy_o,
    output logic              sclk_o,
    output logic              mosi_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_data_o
);
    localparam int BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        logic              busy;
        logic              sclk;
        logic              done;
        logic [BC_W-1:0]   bitc;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_sh;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.sclk  = 1'b0;
                st_d.bitc  = '0;
                st_d.tx_sh = tx_data_i;
            end
        end else if (tick_i) begin
            if (!st_q.sclk) begin
                // leading (rising) edge: capture
                st_d.sclk  = 1'b1;
                st_d.rx_sh = {st_q.rx_sh[DATA_W-2:0], miso_i};
            end else begin
                // trailing (falling) edge: advance or finish
                st_d.sclk = 1'b0;
                if (st_q.bitc == BC_W'(DATA_W - 1)) begin
                    st_d.busy = 1'b0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.bitc  = st_q.bitc + 1'b1;
                    st_d.tx_sh = {st_q.tx_sh[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o    = st_q.busy;
    assign sclk_o    = st_q.sclk;
    assign mosi_o    = st_q.tx_sh[DATA_W-1];
    assign done_o    = st_q.done;
    assign rx_data_o = st_q.rx_sh;

    // MOSI may only move while SCLK is low (R4)
    assert_mosi_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(mosi_o));

endmodule

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl
    import spi_mst_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 3,
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    typedef struct packed {
        logic              en;
        logic              mst;
        logic [PRE_W-1:0]  pre;
        logic [RATE_W-1:0] rate;
        logic [DATA_W-1:0] hold;
        logic              hold_full;
        logic              tx_armed;
        logic [DATA_W-1:0] rx_buf;
        logic              rx_full;
        logic              rx_armed;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic              wr_en, rd_en, run, start, tx_empty;
    logic              tick, sh_busy, sh_done;
    logic [DATA_W-1:0] sh_rx;

    assign wr_en    = bus_sel && bus_wr;
    assign rd_en    = bus_sel && bus_rd;
    assign run      = st_q.en && st_q.mst;
    assign start    = run && st_q.hold_full && !sh_busy;
    assign tx_empty = !st_q.hold_full;

    spi_mst_clkdiv #(.PRE_W(PRE_W), .RATE_W(RATE_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (sh_busy),
        .pre_i  (st_q.pre),
        .rate_i (st_q.rate),
        .tick_o (tick)
    );

    spi_mst_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .tx_data_i (st_q.hold),
        .tick_i    (tick),
        .miso_i    (spi_miso),
        .busy_o    (sh_busy),
        .sclk_o    (spi_sclk),
        .mosi_o    (spi_mosi),
        .done_o    (sh_done),
        .rx_data_o (sh_rx)
    );

    always_comb begin
        st_d = st_q;

        if (start) st_d.hold_full = 1'b0;

        if (wr_en) begin
            case (spi_addr_e'(bus_addr))
                ADDR_CTRL: begin
                    st_d.en  = bus_wdata[CTRL_EN_BIT];
                    st_d.mst = bus_wdata[CTRL_MST_BIT];
                end
                ADDR_BAUD: begin
                    st_d.rate = bus_wdata[RATE_W-1:0];
                    st_d.pre  = bus_wdata[RATE_W +: PRE_W];
                end
                ADDR_DATA: begin
                    if (!st_q.hold_full && st_q.tx_armed) begin
                        st_d.hold      = bus_wdata;
                        st_d.hold_full = 1'b1;
                        st_d.tx_armed  = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        if (rd_en) begin
            case (spi_addr_e'(bus_addr))
                ADDR_STAT: begin
                    st_d.rx_armed = st_q.rx_full;
                    st_d.tx_armed = !st_q.hold_full;
                end
                ADDR_DATA: begin
                    if (st_q.rx_armed && st_q.rx_full) begin
                        st_d.rx_full  = 1'b0;
                        st_d.rx_armed = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        // flag value before any same-cycle clear decides whether the byte lands
        if (sh_done && !st_q.rx_full) begin
            st_d.rx_buf  = sh_rx;
            st_d.rx_full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (spi_addr_e'(bus_addr))
            ADDR_CTRL: begin
                bus_rdata[CTRL_EN_BIT]  = st_q.en;
                bus_rdata[CTRL_MST_BIT] = st_q.mst;
            end
            ADDR_BAUD: begin
                bus_rdata[RATE_W-1:0]     = st_q.rate;
                bus_rdata[RATE_W +: PRE_W] = st_q.pre;
            end
            ADDR_STAT: begin
                bus_rdata[STAT_RXF_BIT] = st_q.rx_full;
                bus_rdata[STAT_TXE_BIT] = tx_empty;
            end
            default: bus_rdata = st_q.rx_buf;
        endcase
    end

    assert_start_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_busy) |-> $past(st_q.en && st_q.mst));

    assert_txe_back_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sh_busy) |-> tx_empty);

    assert_txe_clear_armed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_empty) |-> $past(wr_en && (bus_addr == ADDR_DATA) && st_q.tx_armed));

    assert_rxf_from_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rx_full) |-> $past(sh_done));

    assert_rx_keep_old_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rx_full |=> $stable(st_q.rx_buf));

endmodule

// File: tb/spi_master_ctrl_tb.sv
module spi_master_ctrl_tb;
    import spi_mst_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       sclk, mosi;

    int tests = 0;
    int failed = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // monitor state
    logic       sclk_prev = 1'b0;
    int         rise_cnt = 0;
    int         rise_t = 0, prev_rise_t = 0, fall_t = 0;
    logic [7:0] cap = 8'd0;

    always #5 clk = ~clk;

    spi_master_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_rd    (rd),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .spi_sclk  (sclk),
        .spi_mosi  (mosi),
        .spi_miso  (mosi)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (sclk && !sclk_prev) begin
            rise_cnt    <= rise_cnt + 1;
            prev_rise_t <= rise_t;
            rise_t      <= cyc;
            cap         <= {cap[6:0], mosi};
        end
        if (!sclk && sclk_prev) fall_t <= cyc;
        sclk_prev <= sclk;
    end

    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            failed = failed + 1;
            tests = tests + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        tests = tests + 1;
        if (act != exp) begin
            failed = failed + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0; rd = 1'b0;
    endtask

    task automatic wait_rx(input string req);
        logic [7:0] s;
        int n = 0;
        s = 8'd0;
        while (!s[0] && n < 4000) begin
            bus_read(ADDR_STAT, s);
            n++;
        end
        check(req, int'(s[0]), 1);
    endtask

    initial begin
        logic [7:0] s, d, b;
        int base, h;
        s = 0; d = 0; b = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        @(negedge clk);
        check("R11 sclk", int'(sclk), 0);
        check("R11 mosi", int'(mosi), 0);
        bus_read(ADDR_CTRL, d); check("R11 ctrl", d, 8'h00);
        bus_read(ADDR_BAUD, d); check("R11 baud", d, 8'h00);
        bus_read(ADDR_STAT, d); check("R11 status", d, 8'h02);

        // R3: master only, then enable only -> byte held, no clock
        base = rise_cnt;
        bus_write(ADDR_CTRL, 8'h02);
        bus_read(ADDR_STAT, s);
        bus_write(ADDR_DATA, 8'h3C);
        repeat (40) @(negedge clk);
        check("R3 no edges master-only", rise_cnt - base, 0);
        bus_read(ADDR_STAT, s); check("R3 held master-only", s, 8'h00);
        bus_write(ADDR_CTRL, 8'h01);
        repeat (40) @(negedge clk);
        check("R3 no edges enable-only", rise_cnt - base, 0);
        check("R3 sclk low", int'(sclk), 0);
        bus_read(ADDR_STAT, s); check("R3 held enable-only", s, 8'h00);
        bus_write(ADDR_CTRL, 8'h03);
        wait_rx("R3 frame after enable");
        bus_read(ADDR_STAT, s);
        bus_read(ADDR_DATA, d); check("R3 byte", d, 8'h3C);

        // R1/R2/R4/R7 sweep over prescale and rate
        for (int p = 0; p < 4; p++) begin
            for (int r = 0; r < 4; r++) begin
                h = (p + 1) << r;
                b = 8'h96 ^ 8'((p << 4) | (r << 1) | 1);
                bus_write(ADDR_BAUD, 8'((p << 3) | r));
                bus_read(ADDR_STAT, s);
                bus_write(ADDR_DATA, b);
                wait_rx("R7 flag");
                bus_read(ADDR_STAT, s);
                bus_read(ADDR_DATA, d);
                check("R7 data", d, b);
                check("R4 msb-first wire order", cap, b);
                check("R1 period", rise_t - prev_rise_t, 2 * h);
                check("R1 high time", fall_t - rise_t, h);
                if (p == 0 && r == 0) check("R2 fastest period", rise_t - prev_rise_t, 2);
            end
        end
        bus_read(ADDR_STAT, s); check("R8 cleared after sequence", s, 8'h02);

        // slow setting for buffering tests: P=3, R=3 -> half 32
        bus_write(ADDR_BAUD, 8'h1B);
        h = 32;

        // R5 / R10: second byte queued during a frame
        bus_read(ADDR_STAT, s);
        bus_write(ADDR_DATA, 8'hA1);
        repeat (4) @(negedge clk);
        bus_read(ADDR_STAT, s); check("R5 free while shifting", s, 8'h02);
        bus_write(ADDR_DATA, 8'hA2);
        bus_read(ADDR_STAT, s); check("R5 cleared by write", s, 8'h00);
        wait_rx("R10 first flag");
        bus_read(ADDR_STAT, s);
        bus_read(ADDR_DATA, d); check("R10 first byte", d, 8'hA1);
        wait_rx("R10 second flag");
        bus_read(ADDR_STAT, s);
        bus_read(ADDR_DATA, d); check("R10 second byte", d, 8'hA2);

        // R9 / R8: two frames complete with nobody reading
        bus_read(ADDR_STAT, s);
        bus_write(ADDR_DATA, 8'hB1);
        repeat (4) @(negedge clk);
        bus_read(ADDR_STAT, s);
        bus_write(ADDR_DATA, 8'hB2);
        repeat (40 * h + 60) @(negedge clk);
        bus_read(ADDR_DATA, d); check("R9 older byte kept", d, 8'hB1);
        bus_read(ADDR_STAT, s); check("R8 no clear without status read", s, 8'h03);
        bus_read(ADDR_DATA, d); check("R9 still older byte", d, 8'hB1);
        bus_read(ADDR_STAT, s); check("R9 newer byte dropped", s, 8'h02);

        // R6: write without a fresh status read is ignored
        base = rise_cnt;
        bus_read(ADDR_STAT, s);
        bus_write(ADDR_DATA, 8'hC1);
        bus_write(ADDR_DATA, 8'hC2);
        repeat (40 * h + 60) @(negedge clk);
        check("R6 single frame only", rise_cnt - base, 8);
        bus_read(ADDR_STAT, s); check("R6 status", s, 8'h03);
        bus_read(ADDR_DATA, d); check("R6 accepted byte", d, 8'hC1);

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, failed);
            $finish;
        end
    end

endmodule